// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns characters of 5 to 9 bits into asynchronous serial frames on a single output line. A frame is a low start bit, the data bits with the least significant bit first, an optional parity bit and a stop period that lasts 1, 1.5 or 2 bit times. After the stop period, an optional idle gap of up to 255 bit times can follow before the next frame starts. A one-entry holding register accepts the next character while the current one is still being shifted out.

Timing comes from an external oversampling tick; one bit time is 16 ticks. The frame settings (length, parity, stop period and gap) are taken at the moment a character moves from the holding register into the shifter. The software can therefore reprogram them for the next character while the current one is still going out. In multidrop operation a one-cycle address request marks the next accepted character as an address, and the parity slot carries that mark.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, txd is 1, ready is 1 and empty is 1.
- R2: A frame starts with 16 ticks of low level and then sends the data bits for 16 ticks each, least significant bit first. Where nine_bit is 0, the number of data bits is len_code + 5 (len_code 0 gives 5 bits, 3 gives 8 bits). The line is high when idle.
- R3: Where nine_bit is 1, the frame carries 9 data bits whatever the value of len_code.
- R4: The par_mode encodings are as follows. 0 makes the count of ones in the data and parity together even. 1 makes it odd. 2 forces the parity bit to 0 and 3 forces it to 1. 4 and 5 send no parity bit. 6 and 7 select multidrop. The parity bit lasts 16 ticks and comes right after the last data bit.
- R5: In multidrop mode the parity bit is 1 for an address character and 0 for a data character. A send_addr pulse marks the next write that is accepted (including a write in the same cycle) as an address, and only that write.
- R6: The line is high for the stop period: 16 ticks when stop_mode is 0, 24 ticks when it is 1, and 32 ticks when it is 2 or 3.
- R7: After the stop period the line stays high for guard_bits × 16 further ticks before the next start bit. empty stays 0 during that gap.
- R8: ready is 1 exactly when the holding register is free. A write in a cycle where ready is 1 is accepted. A write in a cycle where ready is 0 is ignored and never transmitted.
- R9: empty is 1 only when the holding register is free and no frame or gap is in progress.
- R10: The settings are captured when a character enters the shifter. Changing them while the frame is on the line does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling tick, 16 per bit time |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send |
| len_code | input | 2 | Data length minus 5, for 5 to 8 bits |
| nine_bit | input | 1 | Forces 9 data bits |
| par_mode | input | 3 | Parity selection |
| stop_mode | input | 2 | Stop period selection |
| guard_bits | input | 8 | Idle bit times after each frame |
| send_addr | input | 1 | Marks the next accepted write as an address |
| txd | output | 1 | Serial line |
| ready | output | 1 | Holding register can accept a write |
| empty | output | 1 | Holding register and shifter both idle |

## Verification
The most difficult case to create from the ports is a write that arrives at the exact edge where the holding register passes its character to an idle shifter. At that edge ready is still 0, so the write must be dropped. The bench produces this case by writing on two consecutive cycles into an idle block.

A second hard case is a change of settings in the middle of a frame. The bench changes the settings only after the start bit is on the line, and a reference model built from a queue of line levels, one level per tick, shows whether the frame kept its original shape.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_W  = 9;
    localparam int OVS     = 16;
    localparam int GUARD_W = 8;
    localparam int CNT_W   = $clog2(2 * OVS + 1);
    localparam int IDX_W   = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_GUARD
    } tx_state_e;

    typedef enum logic [2:0] {
        PAR_EVEN = 3'd0, PAR_ODD = 3'd1, PAR_ZERO = 3'd2, PAR_ONE = 3'd3,
        PAR_OFF_A = 3'd4, PAR_OFF_B = 3'd5, PAR_DROP_A = 3'd6, PAR_DROP_B = 3'd7
    } par_sel_e;

    typedef struct packed {
        logic [1:0]         len_code;
        logic               nine;
        par_sel_e           par;
        logic [1:0]         stop;
        logic [GUARD_W-1:0] guard;
    } frame_cfg_t;

    function automatic logic [IDX_W-1:0] data_bits(frame_cfg_t c);
        return c.nine ? IDX_W'(DATA_W) : IDX_W'(c.len_code) + IDX_W'(5);
    endfunction

    function automatic logic parity_on(par_sel_e p);
        return !(p == PAR_OFF_A || p == PAR_OFF_B);
    endfunction

    function automatic logic [CNT_W-1:0] stop_ticks(logic [1:0] s);
        case (s)
            2'd0:    return CNT_W'(OVS);
            2'd1:    return CNT_W'(OVS + OVS / 2);
            default: return CNT_W'(2 * OVS);
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              addr_req,
    input  logic              take,
    output logic              hold_valid,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_addr
);
    logic addr_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
            hold_addr  <= 1'b0;
            addr_pend  <= 1'b0;
        end else if (wr_en && !hold_valid) begin
            hold_valid <= 1'b1;
            hold_data  <= wr_data;
            hold_addr  <= addr_pend | addr_req;
            addr_pend  <= 1'b0;
        end else begin
            if (take)     hold_valid <= 1'b0;
            if (addr_req) addr_pend  <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
    import uart_tx_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  frame_cfg_t        cfg,
    input  logic              is_addr,
    output logic              par_bit
);
    logic [DATA_W-1:0] mask;
    logic              odd_ones;

    always_comb begin
        mask     = DATA_W'((DATA_W+1)'(1) << data_bits(cfg)) - DATA_W'(1);
        odd_ones = ^(data & mask);
        case (cfg.par)
            PAR_EVEN:               par_bit = odd_ones;
            PAR_ODD:                par_bit = ~odd_ones;
            PAR_ONE:                par_bit = 1'b1;
            PAR_DROP_A, PAR_DROP_B: par_bit = is_addr;
            default:                par_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              hold_valid,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              par_bit,
    input  frame_cfg_t        cfg,
    output logic              take,
    output logic              busy,
    output logic              txd
);
    tx_state_e          state;
    frame_cfg_t         cfg_q;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   lim;
    logic [IDX_W-1:0]   idx;
    logic [DATA_W-1:0]  sh;
    logic               par_q;
    logic [GUARD_W-1:0] guard_left;

    assign take = (state == ST_IDLE) && hold_valid;
    assign busy = (state != ST_IDLE);
    assign lim  = (state == ST_STOP) ? stop_ticks(cfg_q.stop) : CNT_W'(OVS);

    always_comb begin
        case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = sh[0];
            ST_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cfg_q      <= '0;
            cnt        <= '0;
            idx        <= '0;
            sh         <= '0;
            par_q      <= 1'b0;
            guard_left <= '0;
        end else if (take) begin
            state <= ST_START;
            cnt   <= '0;
            idx   <= '0;
            sh    <= hold_data;
            par_q <= par_bit;
            cfg_q <= cfg;
        end else if (busy && tick) begin
            if (cnt != lim - CNT_W'(1)) begin
                cnt <= cnt + CNT_W'(1);
            end else begin
                cnt <= '0;
                case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        sh <= sh >> 1;
                        if (idx == data_bits(cfg_q) - IDX_W'(1))
                            state <= parity_on(cfg_q.par) ? ST_PAR : ST_STOP;
                        else
                            idx <= idx + IDX_W'(1);
                    end
                    ST_PAR: state <= ST_STOP;
                    ST_STOP: begin
                        guard_left <= cfg_q.guard;
                        state      <= (cfg_q.guard != '0) ? ST_GUARD : ST_IDLE;
                    end
                    ST_GUARD: begin
                        guard_left <= guard_left - GUARD_W'(1);
                        if (guard_left == GUARD_W'(1)) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [1:0]         len_code,
    input  logic               nine_bit,
    input  logic [2:0]         par_mode,
    input  logic [1:0]         stop_mode,
    input  logic [GUARD_W-1:0] guard_bits,
    input  logic               send_addr,
    output logic               txd,
    output logic               ready,
    output logic               empty
);
    frame_cfg_t        cfg;
    logic              hold_valid;
    logic [DATA_W-1:0] hold_data;
    logic              hold_addr;
    logic              take;
    logic              busy;
    logic              par_bit;

    always_comb begin
        cfg.len_code = len_code;
        cfg.nine     = nine_bit;
        cfg.par      = par_sel_e'(par_mode);
        cfg.stop     = stop_mode;
        cfg.guard    = guard_bits;
    end

    uart_tx_hold u_hold (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .addr_req(send_addr), .take(take), .hold_valid(hold_valid),
        .hold_data(hold_data), .hold_addr(hold_addr)
    );

    uart_tx_parity u_par (
        .data(hold_data), .cfg(cfg), .is_addr(hold_addr), .par_bit(par_bit)
    );

    uart_tx_shifter u_shift (
        .clk(clk), .rst(rst), .tick(tick), .hold_valid(hold_valid),
        .hold_data(hold_data), .par_bit(par_bit), .cfg(cfg),
        .take(take), .busy(busy), .txd(txd)
    );

    assign ready = !hold_valid;
    assign empty = !hold_valid && !busy;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic txd,
    input logic ready,
    input logic empty
);
    // R8
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && ready |=> !ready);

    // R9
    empty_ready_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> ready);

    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> txd);

    // R9
    busy_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        empty && wr_en |=> !empty);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(txd) |-> !empty);
endmodule

bind uart_frame_tx uart_frame_tx_chk i_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .txd(txd), .ready(ready), .empty(empty)
);

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic [1:0] len_code = 2'd3;
    logic       nine_bit = 1'b0;
    logic [2:0] par_mode = 3'd4;
    logic [1:0] stop_mode = 2'd0;
    logic [7:0] guard_bits = '0;
    logic       send_addr = 1'b0;
    logic       txd, ready, empty;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    tick_per = 1;
    string cur_req = "R1";
    bit    done = 0;

    always #10 clk = ~clk;

    uart_frame_tx i_uart_frame_tx (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .len_code(len_code), .nine_bit(nine_bit), .par_mode(par_mode),
        .stop_mode(stop_mode), .guard_bits(guard_bits), .send_addr(send_addr),
        .txd(txd), .ready(ready), .empty(empty)
    );

    // reference model: one queued line level per tick
    bit       m_q[$];
    bit       m_hold, m_addr, m_pend, m_h0;
    bit [8:0] m_data;

    task automatic push_n(bit v, int n);
        for (int i = 0; i < n; i++) m_q.push_back(v);
    endtask

    task automatic build_frame();
        int nb, ones, st;
        bit pb, has_p;
        nb = nine_bit ? 9 : int'(len_code) + 5;
        ones = 0;
        push_n(1'b0, 16);
        for (int i = 0; i < nb; i++) begin
            push_n(m_data[i], 16);
            if (m_data[i]) ones++;
        end
        has_p = 1;
        case (par_mode)
            3'd0: pb = (ones % 2) == 1;
            3'd1: pb = (ones % 2) == 0;
            3'd2: pb = 0;
            3'd3: pb = 1;
            3'd6, 3'd7: pb = m_addr;
            default: begin pb = 0; has_p = 0; end
        endcase
        if (has_p) push_n(pb, 16);
        st = (stop_mode == 0) ? 16 : (stop_mode == 1) ? 24 : 32;
        push_n(1'b1, st);
        push_n(1'b1, int'(guard_bits) * 16);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_q.delete(); m_hold = 0; m_addr = 0; m_pend = 0; m_data = '0;
        end else begin
            m_h0 = m_hold;
            if (m_q.size() == 0 && m_hold) begin
                build_frame();
                m_hold = 0;
            end else if (tick && m_q.size() != 0) begin
                void'(m_q.pop_front());
            end
            if (wr_en && !m_h0) begin
                m_hold = 1; m_data = wr_data; m_addr = m_pend | send_addr; m_pend = 0;
            end else if (send_addr) begin
                m_pend = 1;
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(cur_req, "txd", int'(txd), (m_q.size() != 0) ? int'(m_q[0]) : 1);
            check(cur_req, "ready", int'(ready), int'(!m_hold));
            check(cur_req, "empty", int'(empty), int'(!m_hold && m_q.size() == 0));
        end
    end

    // tick generator
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1 >= tick_per) ? 0 : ph + 1;
            tick = (ph == 0);
        end
    end

    task automatic send(input logic [8:0] d, input bit addr);
        int w;
        w = 0;
        while (!ready && w < 20000) begin @(negedge clk); w++; end
        wr_en = 1; wr_data = d; send_addr = addr;
        @(negedge clk);
        wr_en = 0; send_addr = 0;
    endtask

    task automatic wait_idle();
        int w;
        w = 0;
        while (!(empty && m_q.size() == 0 && !m_hold) && w < 20000) begin
            @(negedge clk); w++;
        end
        if (w >= 20000) check(cur_req, "idle timeout", 0, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1", "txd after reset", int'(txd), 1);
        check("R1", "ready after reset", int'(ready), 1);
        check("R1", "empty after reset", int'(empty), 1);

        // R2 8-bit and 5-bit frames, two tick rates
        cur_req = "R2"; len_code = 3; par_mode = 4;
        send(9'h0A5, 0); wait_idle();
        tick_per = 3; len_code = 0;
        send(9'h013, 0); wait_idle();
        tick_per = 1;

        // R3 nine-bit override
        cur_req = "R3"; nine_bit = 1; len_code = 0; par_mode = 0;
        send(9'h1A5, 0); wait_idle();
        nine_bit = 0;

        // R4 parity encodings
        cur_req = "R4"; len_code = 2;
        for (int p = 0; p < 6; p++) begin
            par_mode = 3'(p);
            send(9'h05B, 0); send(9'h05A, 0); wait_idle();
        end

        // R5 multidrop address marking
        cur_req = "R5"; par_mode = 6; len_code = 3;
        send(9'h042, 1); send(9'h042, 0); wait_idle();
        send_addr = 1; @(negedge clk); send_addr = 0;
        par_mode = 7;
        send(9'h011, 0); send(9'h011, 0); wait_idle();

        // R6 stop periods
        cur_req = "R6"; par_mode = 1;
        for (int s = 0; s < 4; s++) begin
            stop_mode = 2'(s);
            send(9'h0F0, 0); send(9'h00F, 0); wait_idle();
        end
        stop_mode = 1;

        // R7 timeguard, back to back and maximum
        cur_req = "R7"; guard_bits = 3;
        send(9'h081, 0); send(9'h07E, 0); wait_idle();
        guard_bits = 255; tick_per = 2;
        send(9'h001, 0); send(9'h080, 0); wait_idle();
        guard_bits = 0; tick_per = 1;

        // R8 write while holding register full is dropped
        cur_req = "R8"; par_mode = 4; stop_mode = 0;
        wr_en = 1; wr_data = 9'h055; @(negedge clk);
        check("R8", "ready low after accepted write", int'(ready), 0);
        wr_data = 9'h0AA; @(negedge clk);
        wr_en = 0;
        check("R8", "ready free once shifter took char", int'(ready), 1);
        wait_idle();
        check("R8", "empty after single frame", int'(empty), 1);
        check("R8", "line idle after single frame", int'(txd), 1);

        // R10 settings changed mid-frame
        cur_req = "R10"; len_code = 3; par_mode = 0; stop_mode = 2; guard_bits = 1;
        send(9'h0FF, 0);
        repeat (20) @(negedge clk);
        len_code = 0; par_mode = 4; stop_mode = 0; guard_bits = 0;
        wait_idle();
        check("R10", "empty after changed frame", int'(empty), 1);

        cur_req = "R9";
        send(9'h03C, 0); send(9'h0C3, 0); wait_idle();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule